// File: doc/BRIEF.md
# One-Shot Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation converter that performs one conversion per start request. A conversion begins on a software write of 1 to the start flag or on a rising edge of an external trigger pin when trigger starting is selected. At start the block latches its configuration: channel, clock divider, resolution, sample-and-hold and external-amplifier routing. It then counts a sampling phase on a divided conversion clock and resolves the result one bit per conversion-clock tick, from the MSB down. A single comparator bit is the only view of the analog side.

When the last bit is resolved, the approximation value is stored in the result register of the latched channel, the start flag self-clears and an interrupt request is raised. The request stays up until it is acknowledged or cleared by software. In external-amplifier mode the selected channel is routed out to expansion output 0 while the conversion is busy, and the comparator is taken from expansion input 1.

The controller has four states. ST_IDLE moves to ST_SAMPLE on an accepted start. ST_SAMPLE moves to ST_CONVERT when its last sampling tick is consumed. ST_CONVERT moves to ST_FINISH when the lowest active bit is resolved. ST_FINISH always returns to ST_IDLE after one base-clock cycle, and on that edge the result is written and the interrupt is set.

Top module: `sar_oneshot_seq`

## Requirements
- R1: After reset, irq, busy and start_flag are 0 and every channel result register reads 0.
- R2: The conversion clock is clk divided by 4 when cfg_div=0, by 2 when cfg_div=1, and undivided when cfg_div is 2 or 3. A conversion of L conversion-clock ticks sets irq exactly L*D+1 clk edges after the edge that accepted the start, where D is the division ratio.
- R3: With cfg_res10=1 the stored value is the 10-bit code resolved MSB first, with a trial bit kept when cmp_in=1. With cfg_res10=0 only bits 9..2 are resolved and bits 1..0 of the result read 0. The first trial code driven in the conversion phase is 10'h200.
- R4: The result is written only to the register of the channel latched at start. Every other channel keeps its value.
- R5: A conversion starts on an sw_start_wr pulse, or on a rising edge of trig_in when trig_sel=1. A trig_in edge while trig_sel=0 starts nothing.
- R6: With sample-and-hold in effect, a conversion lasts 28 conversion-clock ticks at 8 bits and 33 at 10 bits.
- R7: With sample-and-hold off, a conversion lasts 49 ticks at 8 bits and 59 at 10 bits.
- R8: When cfg_slow_clk=1, sample-and-hold is forced off, so the R7 lengths apply even if cfg_sh_en=1.
- R9: On completion, irq goes to 1 and start_flag and busy go to 0 on the same edge.
- R10: irq clears on the edge after irq_ack or irq_clr is high. If a clear coincides with the completion edge, the set wins.
- R11: While busy, further start pulses, trigger edges and configuration changes have no effect on the running conversion, its channel, its length or its result.
- R12: When cfg_extamp was 1 at start, exp0_route and conv_from_exp1 are 1 for the whole busy period, and mux_sel shows the latched channel. Otherwise both routing outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | 2 | Conversion clock division select |
| cfg_res10 | input | 1 | 1 = 10-bit, 0 = 8-bit resolution |
| cfg_chan | input | 3 | Channel to convert |
| cfg_sh_en | input | 1 | Requests sample-and-hold |
| cfg_slow_clk | input | 1 | Conversion clock is below the sample-and-hold limit |
| cfg_extamp | input | 1 | External-amplifier routing mode |
| sw_start_wr | input | 1 | Software writes 1 to the start flag |
| trig_sel | input | 1 | Enables starting from trig_in |
| trig_in | input | 1 | External trigger pin, rising edge starts |
| cmp_in | input | 1 | Comparator: 1 when input is at or above trial_code |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_clr | input | 1 | Software writes 0 to the request bit |
| rd_chan | input | 3 | Result register read select |
| trial_code | output | 10 | Trial code for the DAC |
| start_flag | output | 1 | Start flag, self-clearing |
| busy | output | 1 | Conversion in progress |
| irq | output | 1 | Conversion-complete interrupt request |
| mux_sel | output | 3 | Latched channel for the analog mux |
| exp0_route | output | 1 | Route selected channel to expansion output 0 |
| conv_from_exp1 | output | 1 | Comparator takes expansion input 1 |
| rd_data | output | 10 | Result register of rd_chan |

## Verification
busy, start_flag and the routing outputs change on the edge that accepts a start, so they are checked just after that edge. The first conversion trial code is due (L-B)*D edges later, where B is the resolved bit count. irq must still be low after L*D edges and must be high after L*D+1 edges. The bench counts edges from the accepting edge and samples 2 ns after each edge. Clear requests act on the next edge, and the result registers are read combinationally once the conversion is idle.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_FINISH  = 2'd3
    } sar_state_e;

endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] div_sel,
    output logic       tick
);
    logic [1:0] cnt;
    logic [1:0] limit;

    always_comb begin
        unique case (div_sel)
            2'd0:    limit = 2'd3;
            2'd1:    limit = 2'd1;
            default: limit = 2'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 2'd1;
        end
    end

    assign tick = run && (cnt == limit);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl import sar_pkg::*; #(
    parameter int RES_W     = 10,
    parameter int LO_BITS   = 8,
    parameter int CHW       = 3,
    parameter int LEN_SH_LO = 28,
    parameter int LEN_SH_HI = 33,
    parameter int LEN_NS_LO = 49,
    parameter int LEN_NS_HI = 59
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic [1:0]       cfg_div,
    input  logic             cfg_res10,
    input  logic [CHW-1:0]   cfg_chan,
    input  logic             sh_eff,
    input  logic             cfg_extamp,
    input  logic             tick,
    input  logic             cmp_in,
    input  logic             irq_ack,
    input  logic             irq_clr,
    output sar_state_e       state_o,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] sar_o,
    output logic             start_flag_o,
    output logic             irq_o,
    output logic [CHW-1:0]   lat_chan_o,
    output logic [1:0]       lat_div_o,
    output logic             lat_ext_o
);
    localparam int TW = $clog2(LEN_NS_HI + 1);
    localparam int IW = $clog2(RES_W);

    sar_state_e       state, nxt;
    logic [TW-1:0]    tick_left, samp_ticks;
    logic [IW-1:0]    bit_idx, last_idx;
    logic [RES_W-1:0] sar_q;
    logic             res10_q;

    always_comb begin
        unique case ({cfg_res10, sh_eff})
            2'b00:   samp_ticks = TW'(LEN_NS_LO - LO_BITS);
            2'b01:   samp_ticks = TW'(LEN_SH_LO - LO_BITS);
            2'b10:   samp_ticks = TW'(LEN_NS_HI - RES_W);
            default: samp_ticks = TW'(LEN_SH_HI - RES_W);
        endcase
    end

    assign last_idx = res10_q ? '0 : IW'(RES_W - LO_BITS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start_req) nxt = ST_SAMPLE;
            ST_SAMPLE:  if (tick && tick_left == TW'(1)) nxt = ST_CONVERT;
            ST_CONVERT: if (tick && bit_idx == last_idx) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_left    <= '0;
            bit_idx      <= '0;
            sar_q        <= '0;
            res10_q      <= 1'b0;
            start_flag_o <= 1'b0;
            irq_o        <= 1'b0;
            lat_chan_o   <= '0;
            lat_div_o    <= '0;
            lat_ext_o    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_req) begin
                    tick_left    <= samp_ticks;
                    bit_idx      <= IW'(RES_W - 1);
                    sar_q        <= '0;
                    res10_q      <= cfg_res10;
                    start_flag_o <= 1'b1;
                    lat_chan_o   <= cfg_chan;
                    lat_div_o    <= cfg_div;
                    lat_ext_o    <= cfg_extamp;
                end
                ST_SAMPLE: if (tick) tick_left <= tick_left - TW'(1);
                ST_CONVERT: if (tick) begin
                    sar_q[bit_idx] <= cmp_in;
                    if (bit_idx != last_idx) bit_idx <= bit_idx - IW'(1);
                end
                ST_FINISH: start_flag_o <= 1'b0;
                default: ;
            endcase
            if (state == ST_FINISH)      irq_o <= 1'b1;
            else if (irq_ack || irq_clr) irq_o <= 1'b0;
        end
    end

    assign state_o = state;
    assign sar_o   = sar_q;
    assign trial_o = sar_q | ((state == ST_CONVERT)
                     ? ({{(RES_W-1){1'b0}}, 1'b1} << bit_idx) : '0);
endmodule

// File: rtl/sar_result_bank.sv
module sar_result_bank #(
    parameter int CH_N  = 8,
    parameter int RES_W = 10,
    localparam int CHW  = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CHW-1:0]   wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CHW-1:0]   rd_idx,
    output logic [RES_W-1:0] rd_data
);
    logic [RES_W-1:0] regs [CH_N];

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (!rst_n)                            regs[g] <= '0;
            else if (wr_en && wr_idx == CHW'(g))   regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];
endmodule

// File: rtl/sar_oneshot_seq.sv
module sar_oneshot_seq import sar_pkg::*; #(
    parameter int CH_N      = 8,
    parameter int RES_W     = 10,
    parameter int LO_BITS   = 8,
    parameter int LEN_SH_LO = 28,
    parameter int LEN_SH_HI = 33,
    parameter int LEN_NS_LO = 49,
    parameter int LEN_NS_HI = 59,
    localparam int CHW      = $clog2(CH_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_div,
    input  logic             cfg_res10,
    input  logic [CHW-1:0]   cfg_chan,
    input  logic             cfg_sh_en,
    input  logic             cfg_slow_clk,
    input  logic             cfg_extamp,
    input  logic             sw_start_wr,
    input  logic             trig_sel,
    input  logic             trig_in,
    input  logic             cmp_in,
    input  logic             irq_ack,
    input  logic             irq_clr,
    input  logic [CHW-1:0]   rd_chan,
    output logic [RES_W-1:0] trial_code,
    output logic             start_flag,
    output logic             busy,
    output logic             irq,
    output logic [CHW-1:0]   mux_sel,
    output logic             exp0_route,
    output logic             conv_from_exp1,
    output logic [RES_W-1:0] rd_data
);
    sar_state_e       state_w;
    logic             trig_q, start_req, tick, run, lat_ext;
    logic [1:0]       lat_div;
    logic [RES_W-1:0] sar_w;

    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    assign start_req = sw_start_wr || (trig_sel && trig_in && !trig_q);
    assign run       = (state_w == ST_SAMPLE) || (state_w == ST_CONVERT);
    assign busy      = (state_w != ST_IDLE);

    sar_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(lat_div), .tick(tick)
    );

    sar_ctrl #(
        .RES_W(RES_W), .LO_BITS(LO_BITS), .CHW(CHW),
        .LEN_SH_LO(LEN_SH_LO), .LEN_SH_HI(LEN_SH_HI),
        .LEN_NS_LO(LEN_NS_LO), .LEN_NS_HI(LEN_NS_HI)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .cfg_div(cfg_div), .cfg_res10(cfg_res10), .cfg_chan(cfg_chan),
        .sh_eff(cfg_sh_en && !cfg_slow_clk), .cfg_extamp(cfg_extamp),
        .tick(tick), .cmp_in(cmp_in), .irq_ack(irq_ack), .irq_clr(irq_clr),
        .state_o(state_w), .trial_o(trial_code), .sar_o(sar_w),
        .start_flag_o(start_flag), .irq_o(irq), .lat_chan_o(mux_sel),
        .lat_div_o(lat_div), .lat_ext_o(lat_ext)
    );

    sar_result_bank #(.CH_N(CH_N), .RES_W(RES_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(state_w == ST_FINISH),
        .wr_idx(mux_sel), .wr_data(sar_w), .rd_idx(rd_chan), .rd_data(rd_data)
    );

    assign exp0_route     = busy && lat_ext;
    assign conv_from_exp1 = busy && lat_ext;
endmodule

// File: rtl/sar_oneshot_chk.sv
module sar_oneshot_chk import sar_pkg::*; #(
    parameter int CHW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input sar_state_e     state,
    input logic           busy,
    input logic           start_flag,
    input logic           irq,
    input logic           irq_ack,
    input logic           irq_clr,
    input logic           sw_start_wr,
    input logic [CHW-1:0] mux_sel,
    input logic           exp0_route
);
    assert_irq_from_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state) == ST_FINISH);

    assert_finish_effects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (irq && !busy && !start_flag));

    assert_irq_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || irq_clr) && state != ST_FINISH) |=> !irq);

    assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_FINISH && sw_start_wr) |=> (busy && $stable(mux_sel)));

    assert_route_only_running_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exp0_route |-> start_flag);

    assert_flag_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_flag);
endmodule

bind sar_oneshot_seq sar_oneshot_chk #(.CHW(CHW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_w), .busy(busy),
    .start_flag(start_flag), .irq(irq), .irq_ack(irq_ack), .irq_clr(irq_clr),
    .sw_start_wr(sw_start_wr), .mux_sel(mux_sel), .exp0_route(exp0_route)
);

// File: tb/sim_sar_oneshot_seq.sv
`timescale 1ns/1ps
module sim_sar_oneshot_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_div = '0;
    logic       cfg_res10 = 1'b0, cfg_sh_en = 1'b0, cfg_slow_clk = 1'b0, cfg_extamp = 1'b0;
    logic [2:0] cfg_chan = '0, rd_chan = '0, mux_sel;
    logic       sw_start_wr = 1'b0, trig_sel = 1'b0, trig_in = 1'b0;
    logic       irq_ack = 1'b0, irq_clr = 1'b0, cmp_in;
    logic [9:0] trial_code, rd_data, vin = '0;
    logic       start_flag, busy, irq, exp0_route, conv_from_exp1;
    logic [9:0] model [8];
    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign cmp_in = (vin >= trial_code);

    sar_oneshot_seq u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    function automatic int exp_len(bit r10, bit sh, bit slow);
        bit she = sh && !slow;
        if (r10) return she ? 33 : 59;
        return she ? 28 : 49;
    endfunction

    function automatic int exp_div(int dv);
        return (dv == 0) ? 4 : (dv == 1) ? 2 : 1;
    endfunction

    function automatic logic [9:0] exp_code(logic [9:0] v, bit r10);
        return r10 ? v : (v & 10'h3FC);
    endfunction

    task automatic check_bank(input string req);
        for (int c = 0; c < 8; c++) begin
            rd_chan = 3'(c); #0.5;
            chk(req, int'(rd_data), int'(model[c]));
        end
    endtask

    task automatic run_conv(input int ch, input bit r10, input int dv, input bit sh,
                            input bit slow, input bit ext, input logic [9:0] v,
                            input bit use_trig, input bit disturb, input bit coincide,
                            input bit use_ack);
        int len = exp_len(r10, sh, slow);
        int d   = exp_div(dv);
        int b   = r10 ? 10 : 8;
        int k   = 0;
        cfg_chan = 3'(ch); cfg_res10 = r10; cfg_div = 2'(dv); cfg_sh_en = sh;
        cfg_slow_clk = slow; cfg_extamp = ext; vin = v;
        if (use_trig) begin trig_sel = 1'b1; trig_in = 1'b1; end
        else sw_start_wr = 1'b1;
        step();
        sw_start_wr = 1'b0; trig_in = 1'b0;
        chk("R5 busy after start", int'(busy), 1);
        chk("R5 start_flag set", int'(start_flag), 1);
        chk("R12 exp0_route", int'(exp0_route), int'(ext));
        chk("R12 conv_from_exp1", int'(conv_from_exp1), int'(ext));
        chk("R12 mux_sel", int'(mux_sel), ch);
        if (disturb) begin
            cfg_chan = 3'(ch ^ 1); cfg_res10 = !r10; cfg_div = 2'(dv ^ 1);
            cfg_sh_en = !sh; sw_start_wr = 1'b1; trig_sel = 1'b1; trig_in = 1'b1;
            step(); k = 1;
            sw_start_wr = 1'b0; trig_in = 1'b0;
            chk("R11 mux_sel held while busy", int'(mux_sel), ch);
        end
        repeat ((len - b) * d - k) step();
        chk("R3 first trial code MSB", int'(trial_code), 10'h200);
        repeat (b * d) step();
        chk("R2 R6 R7 irq not yet at L*D", int'(irq), 0);
        chk("R9 still busy at L*D", int'(busy), 1);
        if (coincide) irq_clr = 1'b1;
        step();
        irq_clr = 1'b0;
        model[ch] = exp_code(v, r10);
        chk("R9 R10 irq at L*D+1", int'(irq), 1);
        chk("R9 busy low", int'(busy), 0);
        chk("R9 start_flag cleared", int'(start_flag), 0);
        chk("R12 routing off when idle", int'(exp0_route), 0);
        check_bank("R3 R4 result bank");
        if (use_ack) irq_ack = 1'b1; else irq_clr = 1'b1;
        step();
        irq_ack = 1'b0; irq_clr = 1'b0;
        chk("R10 irq cleared", int'(irq), 0);
        trig_sel = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 8; c++) model[c] = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 start_flag reset", int'(start_flag), 0);
        check_bank("R1 results reset");

        // R5: trigger edge ignored when trigger start not selected
        trig_sel = 1'b0; trig_in = 1'b1; step(); trig_in = 1'b0; step(); step();
        chk("R5 trig ignored when disabled", int'(busy), 0);

        run_conv(3, 1, 0, 1, 0, 0, 10'h2A5, 0, 0, 0, 1); // R6 10-bit /4
        run_conv(7, 0, 2, 0, 0, 0, 10'h3FF, 1, 0, 0, 0); // R7 8-bit trig /1
        run_conv(0, 1, 1, 1, 1, 0, 10'h000, 0, 0, 0, 1); // R8 forced off
        run_conv(5, 1, 3, 1, 0, 1, 10'h155, 0, 1, 0, 0); // R11 R12
        run_conv(2, 0, 1, 1, 0, 0, 10'h203, 0, 0, 1, 1); // R10 coincide
        run_conv(6, 0, 0, 0, 1, 1, 10'h001, 1, 1, 0, 0); // R8 R3 8-bit lows

        for (int i = 0; i < 20; i++) begin
            run_conv(int'($urandom % 8), 1'($urandom), int'($urandom % 4),
                     1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
                     10'($urandom), 1'($urandom), 1'($urandom % 3 == 0),
                     1'($urandom % 4 == 0), 1'($urandom));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule